// File: doc/BRIEF.md
# Single-Precision Float to Signed Word Converter

This unit turns an IEEE-754 binary32 bit pattern into a signed 32-bit two's-complement integer, honouring a 3-bit rounding-mode code supplied with each operand. It sits in a floating-point execution pipe as one registered stage. An operand is accepted whenever `inValid` is high, and its integer result is presented one clock later with `outValid`. No exception flags are produced. Out-of-range inputs, infinities and NaNs map to fixed saturation patterns.

Internally the significand is placed in a 64-bit work word with twelve guard positions below the integer's least significant bit. It is shifted right with sticky jamming, so no discarded bit is lost for rounding purposes. A per-mode increment is then added to the guard field. Overflow is caught in two places: by any set bit above the integer field after the increment, and by a sign disagreement after conditional negation. A small control module decodes the mode and the operand sign into rounding strobes. The datapath module does the arithmetic.

Top module: `fp32_to_int_cvt`

## Requirements
- R1: While `rstN` is low, `outValid` is 0 and `outInt` is 0, whatever is presented on the inputs.
- R2: `outValid` is high in exactly the cycle after a cycle with `inValid` high and `rstN` high, and low otherwise. The matching result appears on `outInt` in that same cycle.
- R3: When `inValid` is low, `outInt` keeps its previous value, whatever `fpIn` and `rndMode` carry.
- R4: An input whose exponent field (bits 30:23) is all ones and whose fraction (bits 22:0) is nonzero gives 0x7FFF_FFFF, for either sign bit (bit 31) and any mode.
- R5: Infinities and every value whose rounded magnitude exceeds the signed range saturate: positive to 0x7FFF_FFFF, negative to 0x8000_0000. Exactly −2^31 converts to 0x8000_0000 without error, and 2147483520.0 converts exactly.
- R6: Mode code 000 rounds to the nearest integer, and an exact half goes to the even neighbour (2.5 gives 2, −2.5 gives −2, 1.5 gives 2).
- R7: Mode code 001 truncates toward zero (2.7 gives 2, −2.7 gives −2, any |x| < 1 gives 0).
- R8: Mode code 010 rounds toward minus infinity (−2.3 gives −3, 2.3 gives 2).
- R9: Mode code 011 rounds toward plus infinity (2.3 gives 3, −2.3 gives −2).
- R10: Mode code 100 rounds to nearest, and an exact half goes away from zero (2.5 gives 3, −2.5 gives −3).
- R11: Mode codes 101, 110 and 111 give the same result as code 000.
- R12: Both zeros give 0. A subnormal gives 0, except that a negative subnormal under code 010 gives 0xFFFF_FFFF and a positive subnormal under code 011 gives 1.
- R13: For a non-NaN input, a nonzero result has the same sign as the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operand on `fpIn`/`rndMode` is to be converted this cycle |
| fpIn | input | 32 | binary32 operand: sign bit 31, exponent 30:23, fraction 22:0 |
| rndMode | input | 3 | Rounding-mode code (000 nearest-even, 001 toward zero, 010 down, 011 up, 100 nearest-away, others as 000) |
| outValid | output | 1 | `outInt` holds the result of the operand accepted in the previous cycle |
| outInt | output | 32 | Signed two's-complement result |

## Verification
The round increment and the ties-to-even clearing act on the same result in one cycle. A half such as 2.5 first carries into the next integer and then has its least significant bit cleared, and a wrong order or a wrong tie detection gives an off-by-one answer. A sweep of every small exponent with the upper fraction bits stepped through all sixteen patterns provokes this. It covers both signs and all eight mode codes, presented back to back, so that exact halves, near-halves and odd and even integer parts all occur. Each result is judged against a behavioural reference that works from the integer part and the exact remainder in wide integers, never from a jammed guard field.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'b000,
    RM_ZERO      = 3'b001,
    RM_DOWN      = 3'b010,
    RM_UP        = 3'b011,
    RM_NEAR_MAX  = 3'b100
  } rndMode_e;

  // Strobes handed from control to datapath for one operand
  typedef struct packed {
    logic loadEn;   // capture the converted value into the output register
    logic incHalf;  // add one half of the integer LSB to the guard field
    logic incFull;  // add all-ones to the guard field (round magnitude up)
    logic tieEven;  // clear the result LSB on an exact half
  } cvtStrobe_t;

endpackage

// File: rtl/fpcvt_ctrl.sv
module fpcvt_ctrl
  import fpcvt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [2:0] rndMode,
  input  logic       signIn,
  output cvtStrobe_t strobe,
  output logic       outValid
);

  logic nearMode;
  logic awayDir;

  // Codes above RM_NEAR_MAX fall back to nearest-even
  always_comb begin
    nearMode = (rndMode == RM_NEAR_EVEN) || (rndMode == RM_NEAR_MAX) ||
               (rndMode > RM_NEAR_MAX);
    awayDir  = ((rndMode == RM_DOWN) && signIn) ||
               ((rndMode == RM_UP) && !signIn);
    strobe.loadEn  = inValid;
    strobe.incHalf = nearMode;
    strobe.incFull = awayDir;
    strobe.tieEven = nearMode && (rndMode != RM_NEAR_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/fpcvt_dp.sv
module fpcvt_dp
  import fpcvt_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter int INT_W   = 32,
  parameter int GUARD_W = 12
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  cvtStrobe_t                   strobe,
  input  logic [EXP_W+FRAC_W:0]        fpIn,
  output logic [INT_W-1:0]             outInt
);

  localparam int SIG_W      = FRAC_W + 1;
  localparam int WIDE_W     = 2 * INT_W;
  localparam int BIAS       = (1 << (EXP_W - 1)) - 1;
  localparam int ALIGN_BIAS = BIAS + FRAC_W + INT_W - GUARD_W;
  localparam int TOP_BIT    = GUARD_W + INT_W;
  localparam int HALF_INC   = 1 << (GUARD_W - 1);
  localparam logic [INT_W-1:0] MAX_POS = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] MAX_NEG = {1'b1, {(INT_W-1){1'b0}}};

  logic               sgn;
  logic [EXP_W-1:0]   expF;
  logic [FRAC_W-1:0]  frac;
  logic               isNan;
  int                 shiftInt;
  logic [WIDE_W-1:0]  sigWide;
  logic [WIDE_W-1:0]  lostMask;
  logic [WIDE_W-1:0]  jammed;
  logic [WIDE_W-1:0]  summed;
  logic [GUARD_W-1:0] roundBits;
  logic [GUARD_W-1:0] incVal;
  logic [INT_W-1:0]   mag;
  logic [INT_W-1:0]   signedRes;
  logic [INT_W-1:0]   satVal;
  logic [INT_W-1:0]   nextRes;
  logic               ovfHigh;
  logic               ovfSign;

  assign {sgn, expF, frac} = fpIn;
  assign isNan = (&expF) && (|frac);

  // Align with sticky jamming
  always_comb begin
    sigWide = '0;
    sigWide[INT_W +: SIG_W] = {|expF, frac};
    shiftInt = ALIGN_BIAS - int'(expF);
    lostMask = '0;
    jammed   = sigWide;
    if (shiftInt >= WIDE_W) begin
      jammed = {{(WIDE_W-1){1'b0}}, |sigWide};
    end else if (shiftInt > 0) begin
      lostMask = ~({WIDE_W{1'b1}} << shiftInt);
      jammed   = (sigWide >> shiftInt) |
                 {{(WIDE_W-1){1'b0}}, |(sigWide & lostMask)};
    end
  end

  // Round, negate, saturate
  always_comb begin
    incVal = '0;
    if (strobe.incFull)      incVal = '1;
    else if (strobe.incHalf) incVal = GUARD_W'(HALF_INC);
    roundBits = jammed[GUARD_W-1:0];
    summed    = jammed + WIDE_W'(incVal);
    ovfHigh   = |summed[WIDE_W-1:TOP_BIT];
    mag       = summed[TOP_BIT-1:GUARD_W];
    if (strobe.tieEven && (roundBits == GUARD_W'(HALF_INC))) mag[0] = 1'b0;
    signedRes = sgn ? ((~mag) + INT_W'(1)) : mag;
    ovfSign   = (|signedRes) && (signedRes[INT_W-1] != sgn);
    satVal    = sgn ? MAX_NEG : MAX_POS;
    if (isNan)                 nextRes = MAX_POS;
    else if (ovfHigh || ovfSign) nextRes = satVal;
    else                       nextRes = signedRes;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              outInt <= '0;
    else if (strobe.loadEn) outInt <= nextRes;
  end

endmodule

// File: rtl/fp32_to_int_cvt.sv
module fp32_to_int_cvt
  import fpcvt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] fpIn,
  input  logic [2:0]  rndMode,
  output logic        outValid,
  output logic [31:0] outInt
);

  cvtStrobe_t strobe;

  fpcvt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .rndMode  (rndMode),
    .signIn   (fpIn[31]),
    .strobe   (strobe),
    .outValid (outValid)
  );

  fpcvt_dp #(
    .EXP_W   (8),
    .FRAC_W  (23),
    .INT_W   (32),
    .GUARD_W (12)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .fpIn   (fpIn),
    .outInt (outInt)
  );

endmodule

// File: rtl/fpcvt_chk.sv
module fpcvt_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] fpIn,
  input logic [2:0]  rndMode,
  input logic        outValid,
  input logic [31:0] outInt
);

  logic nanIn;
  logic infIn;
  logic belowOne;
  assign nanIn    = (&fpIn[30:23]) && (|fpIn[22:0]);
  assign infIn    = (&fpIn[30:23]) && !(|fpIn[22:0]);
  assign belowOne = fpIn[30:23] < 8'd127;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R3
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outInt));

  // R4
  nan_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && nanIn) |=> (outInt == 32'h7FFF_FFFF));

  // R5
  inf_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && infIn) |=>
      (outInt == ($past(fpIn[31]) ? 32'h8000_0000 : 32'h7FFF_FFFF)));

  // R7
  trunc_small_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (rndMode == 3'b001) && belowOne) |=> (outInt == 32'h0));

  // R13
  pos_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !nanIn && !fpIn[31]) |=> !outInt[31]);

  // R13
  neg_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !nanIn && fpIn[31]) |=> (outInt[31] || (outInt == 32'h0)));

endmodule

bind fp32_to_int_cvt fpcvt_chk u_chk (.*);

// File: tb/test_fp32_to_int_cvt.sv
module test_fp32_to_int_cvt;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] fpIn = '0;
  logic [2:0]  rndMode = '0;
  logic        outValid;
  logic [31:0] outInt;

  int    nCmp = 0;
  int    nBad = 0;
  string curTag = "R2";
  string expTag = "R2";
  logic        expV = 1'b0;
  logic [31:0] expI = '0;

  always #2 clk = ~clk;

  fp32_to_int_cvt i_fp32_to_int_cvt (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .fpIn     (fpIn),
    .rndMode  (rndMode),
    .outValid (outValid),
    .outInt   (outInt)
  );

  // Behavioural reference: integer part and exact remainder
  function automatic logic [31:0] refConv(input logic [31:0] a, input logic [2:0] mIn);
    logic s;
    int ex, e, sh;
    logic [2:0] m;
    longint mant, ip, rem, half, mag;
    logic up;
    s  = a[31];
    ex = int'(a[30:23]);
    m  = (mIn > 3'd4) ? 3'd0 : mIn;
    if (ex == 255 && a[22:0] != 0) return 32'h7FFF_FFFF;
    if (ex == 255) return s ? 32'h8000_0000 : 32'h7FFF_FFFF;
    mant = longint'(a[22:0]);
    if (ex != 0) begin
      mant = mant + (64'sd1 << 23);
      e = ex - 127;
    end else begin
      e = -126;
    end
    if (e > 40) return s ? 32'h8000_0000 : 32'h7FFF_FFFF;
    if (e >= 23) begin
      ip = mant << (e - 23); rem = 0; half = 1;
    end else if (23 - e <= 40) begin
      sh = 23 - e;
      ip = mant >> sh;
      rem = mant & ((64'sd1 << sh) - 1);
      half = 64'sd1 << (sh - 1);
    end else begin
      ip = 0; rem = (mant != 0) ? 1 : 0; half = 2;
    end
    case (m)
      3'd0:    up = (rem > half) || ((rem == half) && ip[0]);
      3'd1:    up = 1'b0;
      3'd2:    up = s && (rem != 0);
      3'd3:    up = !s && (rem != 0);
      default: up = (rem >= half);
    endcase
    mag = ip + (up ? 1 : 0);
    if (!s && mag > 64'sd2147483647) return 32'h7FFF_FFFF;
    if (s && mag > 64'sd2147483648) return 32'h8000_0000;
    return s ? 32'(-mag) : 32'(mag);
  endfunction

  function automatic string modeTag(input logic [2:0] m);
    case (m)
      3'd0: return "R6";
      3'd1: return "R7";
      3'd2: return "R8";
      3'd3: return "R9";
      3'd4: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Reference model, one register stage
  always @(posedge clk) begin
    if (!rstN) begin
      expV <= 1'b0;
      expI <= '0;
    end else begin
      expV <= inValid;
      if (inValid) begin
        expI   <= refConv(fpIn, rndMode);
        expTag <= curTag;
      end else begin
        expTag <= "R3";
      end
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      nCmp++;
      if (outValid !== expV) begin
        nBad++;
        $display("FAIL R2: outValid got %b expected %b", outValid, expV);
      end
      nCmp++;
      if (outInt !== expI) begin
        nBad++;
        $display("FAIL %s: outInt got %h expected %h (in %h)", expTag, outInt, expI, fpIn);
      end
    end
  end

  task automatic drive(input logic v, input logic [31:0] a, input logic [2:0] m, input string t);
    @(negedge clk);
    inValid = v;
    fpIn    = a;
    rndMode = m;
    curTag  = t;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int exr;
    // R1: reset state with a live operand on the inputs
    inValid = 1'b1; fpIn = 32'h4020_0000; rndMode = 3'd4;
    repeat (3) @(negedge clk);
    nCmp++;
    if (outValid !== 1'b0 || outInt !== 32'h0) begin
      nBad++;
      $display("FAIL R1: got valid %b int %h expected 0 00000000", outValid, outInt);
    end
    inValid = 1'b0;
    rstN = 1'b1;

    // Directed corners
    drive(1, 32'h3FC0_0000, 3'd0, "R6");   // 1.5 -> 2
    drive(1, 32'h4020_0000, 3'd0, "R6");   // 2.5 -> 2
    drive(1, 32'hC020_0000, 3'd0, "R6");   // -2.5 -> -2
    drive(1, 32'h402C_CCCD, 3'd1, "R7");   // 2.7 -> 2
    drive(1, 32'hC02C_CCCD, 3'd1, "R7");   // -2.7 -> -2
    drive(1, 32'hC013_3333, 3'd2, "R8");   // -2.3 -> -3
    drive(1, 32'h4013_3333, 3'd2, "R8");   // 2.3 -> 2
    drive(1, 32'h4013_3333, 3'd3, "R9");   // 2.3 -> 3
    drive(1, 32'hC013_3333, 3'd3, "R9");   // -2.3 -> -2
    drive(1, 32'h4020_0000, 3'd4, "R10");  // 2.5 -> 3
    drive(1, 32'hC020_0000, 3'd4, "R10");  // -2.5 -> -3
    drive(1, 32'h4020_0000, 3'd5, "R11");
    drive(1, 32'hC020_0000, 3'd6, "R11");
    drive(1, 32'h3FC0_0000, 3'd7, "R11");
    drive(1, 32'h7FC0_0000, 3'd0, "R4");
    drive(1, 32'hFFC0_0001, 3'd2, "R4");
    drive(1, 32'h7F80_0001, 3'd3, "R4");
    drive(1, 32'h7F80_0000, 3'd1, "R5");
    drive(1, 32'hFF80_0000, 3'd3, "R5");
    drive(1, 32'h4F00_0000, 3'd0, "R5");   // 2^31 saturates
    drive(1, 32'hCF00_0000, 3'd1, "R5");   // -2^31 exact
    drive(1, 32'h4EFF_FFFF, 3'd3, "R5");   // largest in range
    drive(1, 32'hD015_02F9, 3'd1, "R5");   // -1e10
    drive(1, 32'h0000_0000, 3'd2, "R12");
    drive(1, 32'h8000_0000, 3'd3, "R12");
    drive(1, 32'h0000_0001, 3'd3, "R12");
    drive(1, 32'h8000_0001, 3'd2, "R12");
    drive(1, 32'h8000_0001, 3'd1, "R12");
    drive(1, 32'h0040_0000, 3'd4, "R12");

    // R3: idle cycles with changing inputs
    repeat (6) drive(0, $urandom, 3'($urandom), "R3");

    // Halves and near-halves, all signs and modes, back to back
    for (int ex = 125; ex <= 131; ex++)
      for (int f = 0; f < 16; f++)
        for (int s = 0; s < 2; s++)
          for (int m = 0; m < 8; m++)
            drive(1, {s[0], ex[7:0], f[3:0], 19'b0}, m[2:0], modeTag(m[2:0]));

    // Random operands with gaps
    repeat (3000) begin
      r   = $urandom;
      exr = ($urandom % 2 == 0) ? int'($urandom % 256) : 110 + int'($urandom % 56);
      drive(($urandom % 4) != 0, {r[31], exr[7:0], r[22:0]}, 3'($urandom), "R13");
    end

    repeat (3) drive(0, 32'h0, 3'd0, "R3");
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule